// File: doc/BRIEF.md
# Fractional Complex Multiplier with Rounding and Saturation

This block takes two complex operands, each a 32-bit word packing two signed 16-bit fractional components, and returns their full complex product in the same packed format. Each component of the product is scaled back to fractional form. The exact product sum is doubled, rounded to 16 bits and clamped to the signed 16-bit range, and each component has its own flag that reports the clamp.

A caller presents both operands with a one-cycle valid strobe. The packed result and the two clamp flags appear together with an output valid strobe two clock edges later. A new operand pair may be accepted on every cycle. Between strobes the output keeps the last result, and the operand inputs have no effect while the input strobe is low.

The block is a two-stage pipeline. The first stage forms the real sum ar·br − ai·bi and the imaginary sum ar·bi + ai·br at a width of 34 bits. The second stage holds one narrowing unit per component, and each unit performs the doubling, rounding and clamping.

Top module: `cplx_frac_mul`

## Requirements
- R1: Operands and result use the same packing. The real part is bits 15:0 and the imaginary part is bits 31:16, and each part is a signed two's-complement 16-bit value.
- R2: The real part of the result is the doubled, rounded and clamped narrowing of ar·br − ai·bi.
- R3: The imaginary part of the result is the doubled, rounded and clamped narrowing of ar·bi + ai·br.
- R4: Narrowing doubles the exact sum, adds 0x8000 and keeps bits 31:16. An exact half therefore rounds toward plus infinity: (128,0)·(128,0) gives real 0x0001, and (−128,0)·(128,0) gives real 0x0000.
- R5: A component whose narrowed value exceeds 32767 becomes 0x7FFF and raises its flag (sat_re for the real part, sat_im for the imaginary part). (−1,0)·(−1,0) gives real 0x7FFF. (−1,−1)·(−1,−1) gives real 0x0000 with no flag, and imaginary 0x7FFF with a flag.
- R6: A component whose narrowed value falls below −32768 becomes 0x8000 and raises its flag.
- R7: A component's flag is low whenever that component was not clamped, independently of the other component.
- R8: out_valid is high exactly two rising edges after the edge that samples in_valid high. Operand pairs on consecutive cycles produce results on consecutive cycles.
- R9: While out_valid is low, result, sat_re and sat_im hold their last values. Operands presented with in_valid low are ignored.
- R10: After reset, out_valid, result, sat_re and sat_im are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand {imag, real} |
| op_b | input | 32 | Second operand {imag, real} |
| out_valid | output | 1 | Result strobe, two edges after in_valid |
| result | output | 32 | Packed product {imag, real} |
| sat_re | output | 1 | Real part was clamped |
| sat_im | output | 1 | Imaginary part was clamped |

## Verification
The bench drives the full-scale corners. (−1,0) squared must clamp the real part: a design that only doubles the sum would wrap it to 0x8000. (−1,−1) squared must give a real part of exactly zero: a design that mixes the signs of the cross terms would flag it. A pair is chosen that drives the real part to the negative limit, and a design whose narrowing path is too narrow wraps that value instead of clamping it. Exact-half products on both signs expose truncation, or rounding away from zero, in place of the add-0x8000 rule. Back-to-back strobes and idle cycles with garbage operands catch a pipeline that drops, repeats or leaks results.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    // Default width of one signed component.
    localparam int CFM_CW = 16;

    // Width of a product sum: one bit for the subtraction, one spare bit for the doubling.
    function automatic int cfm_sum_w(input int cw);
        return 2 * cw + 2;
    endfunction

endpackage

// File: rtl/cfm_prod_stage.sv
module cfm_prod_stage #(
    parameter int CW = 16,
    localparam int SW = 2 * CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [2*CW-1:0]      op_a,
    input  logic [2*CW-1:0]      op_b,
    output logic                 s1_valid,
    output logic signed [SW-1:0] s1_re,
    output logic signed [SW-1:0] s1_im
);

    localparam logic signed [SW-1:0] SUM_LIM = SW'(1) <<< (2 * CW - 1);

    logic signed [CW-1:0]   a_re, a_im, b_re, b_im;
    logic signed [2*CW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [SW-1:0]   sum_re, sum_im;

    always_comb begin
        a_re   = op_a[CW-1:0];
        a_im   = op_a[2*CW-1:CW];
        b_re   = op_b[CW-1:0];
        b_im   = op_b[2*CW-1:CW];
        p_rr   = a_re * b_re;
        p_ii   = a_im * b_im;
        p_ri   = a_re * b_im;
        p_ir   = a_im * b_re;
        sum_re = SW'(p_rr) - SW'(p_ii);
        sum_im = SW'(p_ri) + SW'(p_ir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_re    <= '0;
            s1_im    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_re <= sum_re;
                s1_im <= sum_im;
            end
        end
    end

    // R2 R3
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_re <= SUM_LIM && s1_re >= -SUM_LIM &&
                      s1_im <= SUM_LIM && s1_im >= -SUM_LIM));

endmodule

// File: rtl/cfm_narrow.sv
module cfm_narrow #(
    parameter int CW = 16,
    parameter int SW = 2 * CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [SW-1:0] sum_in,
    output logic [CW-1:0]        q,
    output logic                 sat
);

    localparam int DW = SW + 1;
    localparam int TW = DW - CW + 1;
    localparam logic signed [DW-1:0] HALF = DW'(1) <<< (CW - 1);
    localparam logic [CW-1:0] QPOS = {1'b0, {(CW-1){1'b1}}};
    localparam logic [CW-1:0] QNEG = {1'b1, {(CW-1){1'b0}}};

    logic signed [DW-1:0] dbl, rnd, hi_full;
    logic [TW-1:0]        top_bits;
    logic                 fits;
    logic [CW-1:0]        next_q;

    always_comb begin
        dbl      = {sum_in, 1'b0};
        rnd      = dbl + HALF;
        hi_full  = rnd >>> CW;
        top_bits = hi_full[DW-1:CW-1];
        fits     = (&top_bits) || (~|top_bits);
        if (fits)
            next_q = hi_full[CW-1:0];
        else if (hi_full[DW-1])
            next_q = QNEG;
        else
            next_q = QPOS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            sat <= 1'b0;
        end else if (en) begin
            q   <= next_q;
            sat <= !fits;
        end
    end

    // R5 R6
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat |-> (q == QPOS || q == QNEG));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(q) && $stable(sat)));

    // R7
    zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sum_in == '0) |=> (!sat && q == '0));

endmodule

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul
    import cfm_pkg::*;
#(
    parameter int CW = CFM_CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2*CW-1:0] op_a,
    input  logic [2*CW-1:0] op_b,
    output logic            out_valid,
    output logic [2*CW-1:0] result,
    output logic            sat_re,
    output logic            sat_im
);

    localparam int SW = cfm_sum_w(CW);

    logic                 s1_valid;
    logic signed [SW-1:0] s1_sum [2];
    logic [1:0]           sat_v;

    cfm_prod_stage #(.CW(CW)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .s1_valid (s1_valid),
        .s1_re    (s1_sum[0]),
        .s1_im    (s1_sum[1])
    );

    // One narrowing unit per component: index 0 real, index 1 imaginary.
    for (genvar k = 0; k < 2; k++) begin : g_part
        cfm_narrow #(.CW(CW), .SW(SW)) u_narrow (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (s1_valid),
            .sum_in (s1_sum[k]),
            .q      (result[k*CW +: CW]),
            .sat    (sat_v[k])
        );
    end

    always_comb begin
        sat_re = sat_v[0];
        sat_im = sat_v[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= s1_valid;
    end

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

endmodule

// File: tb/sim_cplx_frac_mul.sv
`timescale 1ns/1ps
module sim_cplx_frac_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_re;
    logic        sat_im;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string cur_tag = "R10";

    cplx_frac_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .result(result), .sat_re(sat_re), .sat_im(sat_im)
    );

    always #2 clk = ~clk;

    // Narrow one exact sum: {flag, 16-bit value}.
    function automatic logic [16:0] nar(input longint s);
        longint h;
        h = (2 * s + 64'sd32768) >>> 16;
        if (h > 32767)       return {1'b1, 16'h7fff};
        else if (h < -32768) return {1'b1, 16'h8000};
        else                 return {1'b0, h[15:0]};
    endfunction

    // Returns {sat_im, sat_re, imag, real}.
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        longint ar, ai, br, bi;
        logic [16:0] nr, ni;
        ar = longint'($signed(a[15:0]));
        ai = longint'($signed(a[31:16]));
        br = longint'($signed(b[15:0]));
        bi = longint'($signed(b[31:16]));
        nr = nar(ar * br - ai * bi);
        ni = nar(ar * bi + ai * br);
        return {ni[16], nr[16], ni[15:0], nr[15:0]};
    endfunction

    // Cycle model: stage 1 and output stage, with the tag of each result.
    logic        v1 = 1'b0, v2 = 1'b0;
    logic [33:0] r1 = '0, rout = '0;
    string       t1 = "R10", tout = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            v1 = 1'b0; v2 = 1'b0; rout = '0; tout = "R10";
        end else begin
            v2 = v1;
            if (v1) begin rout = r1; tout = t1; end
            v1 = in_valid;
            if (in_valid) begin r1 = ref_mul(op_a, op_b); t1 = cur_tag; end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(out_valid == v2, "R8", "out_valid", 34'(out_valid), 34'(v2));
            chk({sat_im, sat_re, result} == rout, tout, "{sat_im,sat_re,result}",
                {sat_im, sat_re, result}, rout);
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk); #1;
        cur_tag  = tag;
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
    endtask

    // R9: garbage operands with in_valid low must be ignored.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
            op_a     = $urandom;
            op_b     = $urandom;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(3);                                           // R10 state held
        send({16'h0000, 16'h4000}, {16'h4000, 16'h0000}, "R1");
        idle(3);
        send({16'h2000, 16'h4000}, {16'h2000, 16'h2000}, "R2");
        send({16'hC000, 16'h1234}, {16'h0F00, 16'hE000}, "R3");
        idle(3);
        send({16'h0000, 16'h0080}, {16'h0000, 16'h0080}, "R4");
        send({16'h0000, 16'hFF80}, {16'h0000, 16'h0080}, "R4");
        send({16'h0080, 16'h0000}, {16'h0000, 16'h0080}, "R4");
        idle(3);
        send({16'h0000, 16'h8000}, {16'h0000, 16'h8000}, "R5");
        idle(2);
        send({16'h8000, 16'h8000}, {16'h8000, 16'h8000}, "R5");
        idle(2);
        send({16'h8000, 16'h8000}, {16'h8000, 16'h7FFF}, "R6");
        idle(2);
        send({16'h0000, 16'h8000}, {16'h0000, 16'h7FFF}, "R7");
        idle(2);
        for (int i = 0; i < 40; i++)                        // R8 back-to-back
            send($urandom, $urandom, "R8");
        idle(10);                                           // R9
        for (int i = 0; i < 400; i++) begin
            send($urandom, $urandom, (i % 2 == 0) ? "R2" : "R3");
            idle(int'($urandom % 3));
        end
        idle(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule